// File: doc/BRIEF.md
# Write-Protected Control Register Bank

A small bank of 32-bit control registers sits behind a single-cycle bus slave port. Each write must pass two gates before it reaches storage. First, the registers are split into partitions, and each partition stays locked until a two-step key sequence is written to that partition's key pair. Second, the whole bank is mirrored in two address windows: a normal window and a privileged window. A per-register claim bit decides whether the normal window may still write that register.

A rejected write leaves every stored value unchanged. It produces a one-cycle error flag on the response, together with a reason code. Reads work from either window whatever the lock or claim state, so software can always inspect the bank. The block is meant to guard configuration registers that only trusted bus masters should change, after they have opened the matching partition on purpose.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset, every partition reads as locked (key status 0), the claim register reads 0, and data register i reads `RST_SEED | i` (default 0xA5000000 | i).
- R2: A partition opens only when KEY0 is written with 0x68EF3490 and the very next write to that partition's key pair is KEY1 with 0xD172BC5A. After that, both key addresses of the partition read 1 in bit 0. Other partitions are not affected.
- R3: A wrong key value or a wrong key order leaves the partition locked. Any key write that does not complete the sequence relocks the partition, including a KEY0 write while the partition is open and a repeat KEY1 write while it is open.
- R4: A write to a data register in a locked partition is ignored, and the response reports error with reason 1 (locked).
- R5: While a register's claim bit is set, a normal-window write to it is ignored and reports reason 2 (claimed). A privileged-window write is still accepted if the partition is open.
- R6: While a register's claim bit is clear, writes from either window are accepted when its partition is open. The new value reads back from both windows.
- R7: The claim register (bit i claims data register i) is written only through the privileged window. A normal-window write to it is ignored with reason 2. It reads back from both windows. It is not subject to partition locks.
- R8: Reads return the stored value from either window in any lock or claim state, and never raise an error.
- R9: Every request gets a response exactly one cycle later. The error flag is a one-cycle pulse that appears only on responses to rejected writes, and the reason is 0 otherwise.
- R10: A normal-window write that is both claimed and locked reports reason 2 (claimed). The same write through the privileged window reports reason 1 (locked).
- R11: Address map (word address, 7 bits). Bit 6 set selects the privileged window. The low 6 bits are the offset: 0x00 + i is data register i (partition = i / REGS_PER_PART); 0x10 + 2p is KEY0 of partition p; 0x11 + 2p is KEY1 of partition p; 0x20 is the claim register. Any other offset reads 0 and ignores writes without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Word address; bit 6 selects the privileged window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| rsp_err_o | output | 1 | Write rejected |
| rsp_reason_o | output | 2 | 0 none, 1 locked, 2 claimed |

## Verification
The lock check and the claim check can both apply to the same write, which makes the reason priority the tricky point. The bench claims a register in a partition that is still locked, then writes it once through each window. The normal-window write must report claimed and the privileged write must report locked, and a follow-up read must show the value unchanged. A second overlap occurs when a key write relocks a partition and a data write follows in the very next cycle. The scoreboard expects that data write to be rejected as locked with no gap.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 7;
  localparam logic [DATA_W-1:0] KEY0_VAL = 32'h68EF3490;
  localparam logic [DATA_W-1:0] KEY1_VAL = 32'hD172BC5A;
  localparam logic [5:0] OFF_KEY_BASE = 6'h10;
  localparam logic [5:0] OFF_CLAIM    = 6'h20;

  typedef enum logic [1:0] {
    REJ_NONE    = 2'd0,
    REJ_LOCKED  = 2'd1,
    REJ_CLAIMED = 2'd2
  } rej_e;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_e;
endpackage

// File: rtl/crb_key_lock.sv
module crb_key_lock
  import crb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key0_we_i,
  input  logic              key1_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  lock_st_e st_q, st_d;

  // any key write that does not finish the pair drops back to locked
  always_comb begin
    st_d = st_q;
    if (key0_we_i)
      st_d = (wdata_i == KEY0_VAL) ? LK_ARMED : LK_LOCKED;
    else if (key1_we_i)
      st_d = (st_q == LK_ARMED && wdata_i == KEY1_VAL) ? LK_OPEN : LK_LOCKED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_LOCKED;
    else         st_q <= st_d;
  end

  assign unlocked_o = (st_q == LK_OPEN);

  p_open_needs_key1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> ($past(key1_we_i) && $past(wdata_i) == KEY1_VAL));

  p_key0_relocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key0_we_i |=> !unlocked_o);
endmodule

// File: rtl/crb_claim_reg.sv
module crb_claim_reg #(
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_REGS-1:0] wdata_i,
  output logic [NUM_REGS-1:0] claim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   claim_o <= '0;
    else if (we_i) claim_o <= wdata_i;
  end

  p_claim_change_needs_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(claim_o) |-> $past(we_i));
endmodule

// File: rtl/crb_write_gate.sv
module crb_write_gate
  import crb_pkg::*;
#(
  parameter int unsigned NUM_PART      = 2,
  parameter int unsigned REGS_PER_PART = 4,
  localparam int unsigned NUM_REGS = NUM_PART * REGS_PER_PART,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  localparam int unsigned RP_W     = $clog2(REGS_PER_PART)
) (
  input  logic                valid_i,
  input  logic                write_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PART-1:0] unlocked_i,
  input  logic [NUM_REGS-1:0] claim_i,
  output logic                hit_data_o,
  output logic                hit_key_o,
  output logic                hit_claim_o,
  output logic [IDX_W-1:0]    data_idx_o,
  output logic [PART_W-1:0]   data_part_o,
  output logic [PART_W-1:0]   key_part_o,
  output logic [NUM_REGS-1:0] data_we_o,
  output logic                claim_we_o,
  output logic [NUM_PART-1:0] key0_we_o,
  output logic [NUM_PART-1:0] key1_we_o,
  output rej_e                rej_o
);
  localparam logic [5:0] NREG_OFF  = 6'(NUM_REGS);
  localparam logic [2:0] NPART_OFF = 3'(NUM_PART);

  logic [5:0] off;
  logic       priv, wr;

  assign off  = addr_i[5:0];
  assign priv = addr_i[ADDR_W-1];
  assign wr   = valid_i & write_i;

  assign hit_data_o  = (off < NREG_OFF);
  assign hit_key_o   = (off[5:4] == OFF_KEY_BASE[5:4]) && (off[3:1] < NPART_OFF);
  assign hit_claim_o = (off == OFF_CLAIM);
  assign data_idx_o  = off[IDX_W-1:0];
  assign data_part_o = PART_W'(data_idx_o >> RP_W);
  assign key_part_o  = PART_W'(off[3:1]);

  // claim is checked before the lock
  always_comb begin
    rej_o = REJ_NONE;
    if (wr) begin
      if (hit_data_o) begin
        if (claim_i[data_idx_o] && !priv) rej_o = REJ_CLAIMED;
        else if (!unlocked_i[data_part_o]) rej_o = REJ_LOCKED;
      end else if (hit_claim_o && !priv) begin
        rej_o = REJ_CLAIMED;
      end
    end
  end

  always_comb begin
    data_we_o = '0;
    key0_we_o = '0;
    key1_we_o = '0;
    if (wr && hit_data_o && rej_o == REJ_NONE) data_we_o[data_idx_o] = 1'b1;
    if (wr && hit_key_o) begin
      if (off[0]) key1_we_o[key_part_o] = 1'b1;
      else        key0_we_o[key_part_o] = 1'b1;
    end
  end

  assign claim_we_o = wr && hit_claim_o && priv;

  always_comb begin
    a_single_target_r11: assert ($countones({hit_data_o, hit_key_o, hit_claim_o}) <= 1);
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
#(
  parameter int unsigned NUM_PART      = 2,
  parameter int unsigned REGS_PER_PART = 4,
  parameter logic [31:0] RST_SEED      = 32'hA500_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [6:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_err_o,
  output logic [1:0]  rsp_reason_o
);
  localparam int unsigned NUM_REGS = NUM_PART * REGS_PER_PART;
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned PART_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] data_q;
  logic [NUM_PART-1:0] unlocked, key0_we, key1_we;
  logic [NUM_REGS-1:0] claim, data_we;
  logic                claim_we, hit_data, hit_key, hit_claim;
  logic [IDX_W-1:0]    data_idx;
  logic [PART_W-1:0]   data_part, key_part;
  rej_e                rej;
  logic [DATA_W-1:0]   rdata_d;
  logic                wr;

  assign wr = req_valid_i & req_write_i;

  crb_write_gate #(
    .NUM_PART(NUM_PART), .REGS_PER_PART(REGS_PER_PART)
  ) u_gate (
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .unlocked_i(unlocked), .claim_i(claim),
    .hit_data_o(hit_data), .hit_key_o(hit_key), .hit_claim_o(hit_claim),
    .data_idx_o(data_idx), .data_part_o(data_part), .key_part_o(key_part),
    .data_we_o(data_we), .claim_we_o(claim_we),
    .key0_we_o(key0_we), .key1_we_o(key1_we), .rej_o(rej)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    crb_key_lock u_lock (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .key0_we_i(key0_we[p]), .key1_we_i(key1_we[p]),
      .wdata_i(req_wdata_i), .unlocked_o(unlocked[p])
    );
  end

  crb_claim_reg #(.NUM_REGS(NUM_REGS)) u_claim (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(claim_we),
    .wdata_i(req_wdata_i[NUM_REGS-1:0]), .claim_o(claim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) data_q[i] <= RST_SEED | DATA_W'(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (data_we[i]) data_q[i] <= req_wdata_i;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (req_valid_i && !req_write_i) begin
      if (hit_data)       rdata_d = data_q[data_idx];
      else if (hit_key)   rdata_d = DATA_W'(unlocked[key_part]);
      else if (hit_claim) rdata_d = DATA_W'(claim);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      rsp_err_o    <= 1'b0;
      rsp_reason_o <= REJ_NONE;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_rdata_o  <= rdata_d;
      rsp_err_o    <= wr && (rej != REJ_NONE);
      rsp_reason_o <= wr ? rej : REJ_NONE;
    end
  end

  p_rsp_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_err_has_reason_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_reason_o != REJ_NONE));

  p_read_no_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> !rsp_err_o);

  p_reject_keeps_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && rej != REJ_NONE) |=> ($stable(data_q) && $stable(claim)));

  p_normal_claimed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_data && !req_addr_i[6] && claim[data_idx])
      |=> (rsp_err_o && rsp_reason_o == REJ_CLAIMED));

  p_priv_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_data && req_addr_i[6] && !unlocked[data_part])
      |=> (rsp_err_o && rsp_reason_o == REJ_LOCKED));
endmodule

// File: tb/ctrl_reg_bank_tb.sv
module ctrl_reg_bank_tb;
  localparam logic [31:0] K0 = 32'h68EF3490;
  localparam logic [31:0] K1 = 32'hD172BC5A;
  localparam logic [31:0] SEED = 32'hA500_0000;
  localparam logic [6:0] PRIV = 7'h40;
  localparam logic [6:0] CLM  = 7'h20;

  typedef struct {
    bit          wr;
    logic [31:0] rd;
    logic [1:0]  rej;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0] rsp_reason;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  ctrl_reg_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .rsp_reason_o(rsp_reason)
  );

  function automatic logic [6:0] k0a(int p); return 7'(16 + 2 * p); endfunction
  function automatic logic [6:0] k1a(int p); return 7'(17 + 2 * p); endfunction

  task automatic xact(bit wr, logic [6:0] a, logic [31:0] d,
                      logic [31:0] exp_rd, logic [1:0] exp_rej, string tag);
    exp_t e;
    @(negedge clk);
    e.wr = wr; e.rd = exp_rd; e.rej = exp_rej; e.tag = tag;
    q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr_(logic [6:0] a, logic [31:0] d, logic [1:0] rej, string tag);
    xact(1'b1, a, d, '0, rej, tag);
  endtask

  task automatic rd_(logic [6:0] a, logic [31:0] exp, string tag);
    xact(1'b0, a, '0, exp, 2'd0, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R9: unexpected response act_valid=1 exp_valid=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rsp_err !== (e.rej != 2'd0) || rsp_reason !== e.rej ||
              (!e.wr && rsp_rdata !== e.rd)) begin
            bad++;
            $display("FAIL %s: act err=%0b reason=%0d rdata=%h exp err=%0b reason=%0d rdata=%h",
                     e.tag, rsp_err, rsp_reason, rsp_rdata, e.rej != 2'd0, e.rej, e.rd);
          end
        end
      end else if (rsp_err) begin
        total++; bad++;
        $display("FAIL R9: err without response act=1 exp=0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      bad++;
      $display("FAIL R1: act valid=%0b err=%0b exp 0 0", rsp_valid, rsp_err);
    end
    // R1 reset state
    rd_(7'h00, SEED, "R1");
    rd_(PRIV | 7'h05, SEED | 32'd5, "R1");
    rd_(k0a(0), 32'd0, "R1");
    rd_(k1a(1), 32'd0, "R1");
    rd_(CLM, 32'd0, "R1");
    // R4 locked write
    wr_(7'h00, 32'h1111, 2'd1, "R4");
    rd_(7'h00, SEED, "R4");
    // R3 wrong order / wrong value
    wr_(k1a(0), K1, 2'd0, "R3");
    wr_(k0a(0), K0, 2'd0, "R3");
    rd_(k0a(0), 32'd0, "R3");
    wr_(k1a(0), 32'h1234, 2'd0, "R3");
    rd_(k1a(0), 32'd0, "R3");
    wr_(k0a(0), 32'h0BAD, 2'd0, "R3");
    wr_(k1a(0), K1, 2'd0, "R3");
    rd_(k0a(0), 32'd0, "R3");
    // R2 unlock partition 0
    wr_(k0a(0), K0, 2'd0, "R2");
    wr_(k1a(0), K1, 2'd0, "R2");
    rd_(k1a(0), 32'd1, "R2");
    rd_(PRIV | k0a(0), 32'd1, "R2");
    rd_(k0a(1), 32'd0, "R2");
    // R6 unclaimed writes from both windows
    wr_(7'h01, 32'h11, 2'd0, "R6");
    rd_(PRIV | 7'h01, 32'h11, "R6");
    wr_(PRIV | 7'h02, 32'h22, 2'd0, "R6");
    rd_(7'h02, 32'h22, "R6");
    // R4 other partition still locked
    wr_(7'h04, 32'h44, 2'd1, "R4");
    rd_(7'h04, SEED | 32'd4, "R4");
    // R7 claim register access
    wr_(CLM, 32'h2, 2'd2, "R7");
    rd_(PRIV | CLM, 32'd0, "R7");
    wr_(PRIV | CLM, 32'h2, 2'd0, "R7");
    rd_(CLM, 32'h2, "R7");
    // R5 claimed register
    wr_(7'h01, 32'h99, 2'd2, "R5");
    rd_(7'h01, 32'h11, "R5");
    wr_(PRIV | 7'h01, 32'h77, 2'd0, "R5");
    rd_(7'h01, 32'h77, "R8");
    // R10 claimed and locked together
    wr_(PRIV | CLM, 32'h12, 2'd0, "R10");
    wr_(7'h04, 32'h55, 2'd2, "R10");
    wr_(PRIV | 7'h04, 32'h55, 2'd1, "R10");
    rd_(PRIV | 7'h04, SEED | 32'd4, "R10");
    // R3 relock by KEY0, then write in the next cycle
    wr_(k0a(0), 32'd0, 2'd0, "R3");
    wr_(PRIV | 7'h02, 32'h66, 2'd1, "R3");
    rd_(k0a(0), 32'd0, "R3");
    rd_(7'h02, 32'h22, "R8");
    // R3 repeat KEY1 while open relocks
    wr_(k0a(0), K0, 2'd0, "R2");
    wr_(k1a(0), K1, 2'd0, "R2");
    rd_(k0a(0), 32'd1, "R2");
    wr_(k1a(0), K1, 2'd0, "R3");
    rd_(k0a(0), 32'd0, "R3");
    // R11 unmapped offsets
    wr_(7'h30, 32'hFFFF, 2'd0, "R11");
    rd_(7'h30, 32'd0, "R11");
    rd_(PRIV | 7'h1F, 32'd0, "R11");
    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: act pending=%0d exp pending=0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule